// File: doc/BRIEF.md
# Five-Stage Linear Feedback Pseudorandom Bit Generator

This block is a five-stage shift register with linear feedback. It produces one pseudorandom bit per enabled clock. Each enabled step moves every stage one place toward the least significant end. The most significant stage then receives the XOR of the stages picked by a tap mask parameter. A mask bit of one adds that stage to the sum, and a mask bit of zero leaves it out, so the mask logic reduces to plain wires and XOR gates.

With the default mask the register cycles through all 31 nonzero values before it repeats. A synchronous reset puts the register at a seed value. A load strobe places any chosen fill in the register, which picks the starting point within the same 31-step cycle. A fill of zero would stop the register for good, so a load of zero is replaced by the value 00001.

Top module: `prng_shift5`

## Requirements
- R1: In the cycle after a synchronous reset, `state` is the seed, 5'b00001 by default.
- R2: When `en` is high and `load` is low, the next `state` is the current value shifted one place right. The new bit 4 is the XOR of the bits selected by `TAP_MASK`; with the default 5'b00101 these are bit 0 and bit 2. Examples: 00001 goes to 10000, 00100 goes to 10010, and 01101 goes to 00110.
- R3: When `en` and `load` are both low, `state` and `bit_out` keep their values.
- R4: When `load` is high and `load_value` is nonzero, the next `state` is `load_value`, whatever the value of `en`.
- R5: When `load` is high and `load_value` is zero, the next `state` is 5'b00001.
- R6: `bit_out` always equals bit 0 of `state`.
- R7: Starting from any nonzero state, `state` returns to that value after exactly 31 enabled steps. Within those steps every nonzero 5-bit value appears exactly once, and zero never appears.
- R8: Over one 31-step period, `bit_out` is one in exactly 16 of the states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the sequence by one step |
| load | input | 1 | Replace the state with `load_value` (takes priority over `en`) |
| load_value | input | 5 | New fill value; zero is replaced by 00001 |
| state | output | 5 | Current register contents |
| bit_out | output | 1 | Pseudorandom output bit, bit 0 of `state` |

## Verification
The hardest case to reach from the ports is the claim about the whole cycle. Only after 31 consecutive enabled steps does it show that every nonzero value is visited once and that zero never appears. The bench runs two full periods from the seed and compares the state with its own model at every step. It marks each value in a visited map and records where the first return to the start value happens. It then loads a different fill and repeats the period check from there. This shows that the fill only moves the starting point within the same cycle.

// File: rtl/prng_shift5.sv
module prng_shift5 #(
  parameter int WIDTH = 5,
  parameter logic [WIDTH-1:0] TAP_MASK = 5'b00101,
  parameter logic [WIDTH-1:0] SEED = 5'b00001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] load_value,
  output logic [WIDTH-1:0] state,
  output logic             bit_out
);
  localparam logic [WIDTH-1:0] SAFE_FILL = WIDTH'(1);

  logic [WIDTH-1:0] sr;
  logic             feedback;
  logic [WIDTH-1:0] fill;

  assign feedback = ^(sr & TAP_MASK);
  assign fill     = (load_value == '0) ? SAFE_FILL : load_value;

  always_ff @(posedge clk) begin
    if (rst)
      sr <= SEED;
    else if (load)
      sr <= fill;
    else if (en)
      sr <= {feedback, sr[WIDTH-1:1]};
  end

  assign state   = sr;
  assign bit_out = sr[0];
endmodule

module prng_shift5_checker #(
  parameter int WIDTH = 5,
  parameter logic [WIDTH-1:0] TAP_MASK = 5'b00101,
  parameter logic [WIDTH-1:0] SEED = 5'b00001
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             load,
  input logic [WIDTH-1:0] load_value,
  input logic [WIDTH-1:0] state,
  input logic             bit_out
);
  logic [WIDTH-1:0] prev_state;
  logic             live;
  logic [WIDTH-1:0] stepped;

  always_ff @(posedge clk) begin
    prev_state <= state;
    live       <= !rst;
  end

  assign stepped = {^(prev_state & TAP_MASK), prev_state[WIDTH-1:1]};

  assert_reset_fill_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> state == SEED);

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    live && $past(en) && !$past(load) |-> state == stepped);

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    live && !$past(en) && !$past(load) |-> $stable(state));

  assert_load_R4: assert property (@(posedge clk) disable iff (rst)
    load && load_value != '0 |=> state == $past(load_value));

  assert_zero_load_R5: assert property (@(posedge clk) disable iff (rst)
    load && load_value == '0 |=> state == WIDTH'(1));

  assert_out_bit_R6: assert property (@(posedge clk) disable iff (rst)
    live |-> bit_out == state[0]);

  assert_never_zero_R7: assert property (@(posedge clk) disable iff (rst)
    live |-> state != '0);
endmodule

bind prng_shift5 prng_shift5_checker #(
  .WIDTH(WIDTH), .TAP_MASK(TAP_MASK), .SEED(SEED)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .load(load),
  .load_value(load_value), .state(state), .bit_out(bit_out)
);

// File: tb/prng_shift5_test.sv
module prng_shift5_test;
  logic       clk = 0;
  logic       rst = 1;
  logic       en = 0;
  logic       load = 0;
  logic [4:0] load_value = '0;
  logic [4:0] state;
  logic       bit_out;
  int tests = 0;
  int fails = 0;

  prng_shift5 uut (.*);

  always #5 clk = ~clk;

  function automatic logic [4:0] model_next(input logic [4:0] s);
    return {s[0] ^ s[2], s[4:1]};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic do_load(input logic [4:0] v, input logic e);
    load = 1; load_value = v; en = e;
    tick();
    load = 0; en = 0;
  endtask

  task automatic period_run(input logic [4:0] start, input string tag);
    logic [31:0] seen;
    int ones, ret_at;
    logic [4:0] m;
    seen = '0; ones = 0; ret_at = -1; m = start;
    en = 1;
    for (int i = 1; i <= 62; i++) begin
      if (i <= 31) begin
        seen[state] = 1'b1;
        ones += int'(bit_out);
      end
      tick();
      m = model_next(m);
      chk({tag, " R2 model compare"}, state, m);
      if (ret_at < 0 && state == start) ret_at = i;
    end
    en = 0;
    chk({tag, " R7 period"}, ret_at, 31);
    chk({tag, " R7 zero never seen"}, int'(seen[0]), 0);
    chk({tag, " R7 nonzero visited"}, $countones(seen), 31);
    chk({tag, " R8 ones count"}, ones, 16);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 0;
    chk("R1 reset fill", state, 5'b00001);
    chk("R6 out bit", bit_out, 1);

    en = 1; tick(); en = 0;
    chk("R2 00001->10000", state, 5'b10000);
    chk("R6 out bit", bit_out, 0);
    do_load(5'b00100, 0);
    chk("R4 load", state, 5'b00100);
    en = 1; tick(); en = 0;
    chk("R2 00100->10010", state, 5'b10010);
    do_load(5'b01101, 0);
    en = 1; tick(); en = 0;
    chk("R2 01101->00110", state, 5'b00110);

    tick(); tick();
    chk("R3 hold state", state, 5'b00110);
    chk("R3 hold out", bit_out, 0);

    do_load(5'b10111, 1);
    chk("R4 load beats enable", state, 5'b10111);
    do_load(5'b00000, 1);
    chk("R5 zero load", state, 5'b00001);
    do_load(5'b00000, 0);
    chk("R5 zero load no enable", state, 5'b00001);

    rst = 1; tick(); rst = 0;
    chk("R1 reset again", state, 5'b00001);
    period_run(5'b00001, "seed");

    do_load(5'b10110, 0);
    chk("R4 load other fill", state, 5'b10110);
    period_run(5'b10110, "fill");

    rst = 1; load = 1; load_value = 5'b11111; tick(); rst = 0; load = 0;
    chk("R1 reset over load", state, 5'b00001);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule